// File: doc/BRIEF.md
# Serially Programmed Alignment Delay Bank

This block realigns five parallel input paths that reach a video mixing datapath with differing upstream latency. The paths are two pixel buses, a mix factor, a two-bit rounding selector and a one-bit number-format flag. Each path passes through its own delay line, and a tap selector sets that line anywhere from zero to seven system clock cycles. A setting of zero passes the input through in the same cycle.

The five 3-bit tap settings are packed into one 15-bit word. That word is loaded one bit per pulse over a slow two-wire interface: a strobe line and a data line. Both lines are synchronized into the system clock domain, and only the rising edges of the strobe count. The word takes effect as a whole once the fifteenth pulse is received. A bypass input overrides the loaded word with zeros, so every path becomes a straight pass-through.

Top module: `alignment_delay_bank`

## Requirements
- R1: Each output equals its input delayed by exactly the path's tap setting in clock cycles, from 0 to 7. A setting of 0 gives the current-cycle input combinationally.
- R2: The control word is mapped to the paths as follows:
  - bits [2:0] control pixel A;
  - bits [5:3] control pixel B;
  - bits [8:6] control the mix factor;
  - bits [11:9] control the rounding selector;
  - bits [14:12] control the format flag.
- R3: Each rising edge of the strobe takes one bit from the data line, as seen after the synchronizer. The first bit sent ends up as word bit 0, and the last bit sent ends up as bit 14.
- R4: The active word does not change until the fifteenth pulse of a load. A partial load leaves every output delay as it was.
- R5: After the fifteenth pulse the pulse count returns to zero. The next fifteen pulses load a fresh word.
- R6: While bypass is 1, every output equals its current input. When bypass returns to 0, the loaded word applies again.
- R7: A synchronous active-high reset does three things:
  - it clears the active word, so all paths pass through;
  - it clears the pulse count;
  - it clears the delay registers to zero.
- R8: A strobe held high for many cycles counts as a single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pix_a_i | input | 12 | Pixel A in |
| pix_b_i | input | 12 | Pixel B in |
| mix_i | input | 12 | Mix factor in |
| rnd_i | input | 2 | Rounding selector in |
| fmt_i | input | 1 | Number-format flag in |
| ld_strobe_i | input | 1 | Serial load strobe, asynchronous |
| ld_data_i | input | 1 | Serial load data, asynchronous |
| bypass_i | input | 1 | Forces all delays to zero |
| pix_a_o | output | 12 | Pixel A aligned |
| pix_b_o | output | 12 | Pixel B aligned |
| mix_o | output | 12 | Mix factor aligned |
| rnd_o | output | 2 | Rounding selector aligned |
| fmt_o | output | 1 | Number-format flag aligned |

## Verification
The hardest case to reach is a load that is interrupted, either by a run of pulses shorter than a full word or by a reset in the middle of a word. In both cases the pulse count must not leak into the next load. The stimulus first sends seven bits of a word while the outputs are being compared against the old word. It then completes the word and checks that the new taps apply. Later it sends five bits, asserts reset, and then sends a full word. If the count survived the reset, that word would commit early with its bits shifted. Long strobe holds and a bypass applied over a nonzero word cover the remaining corners.

// File: rtl/adb_pkg.sv
`timescale 1ns/1ps
package adb_pkg;
    parameter int PIX_W = 12;
    parameter int MIX_W = 12;
    parameter int RND_W = 2;
    parameter int FMT_W = 1;
    parameter int TAP_W = 3;
    parameter int SYNC_STAGES = 2;

    localparam int NUM_PATHS = 5;
    localparam int WORD_W    = NUM_PATHS * TAP_W;
    localparam int CNT_W     = $clog2(WORD_W);

    // Packed MSB first: fmt occupies the top field, pix_a the bottom one.
    typedef struct packed {
        logic [TAP_W-1:0] fmt;
        logic [TAP_W-1:0] rnd;
        logic [TAP_W-1:0] mix;
        logic [TAP_W-1:0] pix_b;
        logic [TAP_W-1:0] pix_a;
    } dly_word_t;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t LAST_BIT = cnt_t'(WORD_W - 1);

    function automatic dly_word_t effective_word(input dly_word_t w, input logic byp);
        return byp ? dly_word_t'('0) : w;
    endfunction
endpackage

// File: rtl/adb_sync.sv
`timescale 1ns/1ps
module adb_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] ff_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ff_q <= '0;
        end else begin
            ff_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                ff_q[i] <= ff_q[i-1];
            end
        end
    end

    assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/adb_serial_loader.sv
`timescale 1ns/1ps
module adb_serial_loader
    import adb_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      strobe_i,
    input  logic      data_i,
    output dly_word_t word_o,
    output cnt_t      cnt_o,
    output logic      rise_o
);
    logic strobe_s, data_s, strobe_d;
    logic [WORD_W-1:0] shift_q, shift_nx;
    cnt_t      cnt_q;
    dly_word_t word_q;

    adb_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   ({strobe_i, data_i}),
        .q_o   ({strobe_s, data_s})
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) strobe_d <= 1'b0;
        else       strobe_d <= strobe_s;
    end

    assign rise_o   = strobe_s & ~strobe_d;
    assign shift_nx = {data_s, shift_q[WORD_W-1:1]};

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            shift_q <= '0;
            cnt_q   <= '0;
            word_q  <= '0;
        end else if (rise_o) begin
            shift_q <= shift_nx;
            if (cnt_q == LAST_BIT) begin
                cnt_q  <= '0;
                word_q <= dly_word_t'(shift_nx);
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign word_o = word_q;
    assign cnt_o  = cnt_q;
endmodule

// File: rtl/adb_tap_delay.sv
`timescale 1ns/1ps
module adb_tap_delay #(
    parameter int W     = 8,
    parameter int TAP_W = 3
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [W-1:0]     din_i,
    input  logic [TAP_W-1:0] sel_i,
    output logic [W-1:0]     dout_o
);
    localparam int DEPTH = (1 << TAP_W) - 1;

    logic [DEPTH-1:0][W-1:0] stage_q;
    logic [DEPTH:0][W-1:0]   tap_w;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= din_i;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    always_comb begin
        tap_w[0] = din_i;
        for (int i = 1; i <= DEPTH; i++) begin
            tap_w[i] = stage_q[i-1];
        end
    end

    assign dout_o = tap_w[sel_i];
endmodule

// File: rtl/alignment_delay_bank.sv
`timescale 1ns/1ps
module alignment_delay_bank
    import adb_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [PIX_W-1:0] pix_a_i,
    input  logic [PIX_W-1:0] pix_b_i,
    input  logic [MIX_W-1:0] mix_i,
    input  logic [RND_W-1:0] rnd_i,
    input  logic [FMT_W-1:0] fmt_i,
    input  logic             ld_strobe_i,
    input  logic             ld_data_i,
    input  logic             bypass_i,
    output logic [PIX_W-1:0] pix_a_o,
    output logic [PIX_W-1:0] pix_b_o,
    output logic [MIX_W-1:0] mix_o,
    output logic [RND_W-1:0] rnd_o,
    output logic [FMT_W-1:0] fmt_o
);
    dly_word_t active_word;
    dly_word_t eff_word;
    cnt_t      load_cnt;
    logic      strobe_rise;

    adb_serial_loader u_loader (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .strobe_i (ld_strobe_i),
        .data_i   (ld_data_i),
        .word_o   (active_word),
        .cnt_o    (load_cnt),
        .rise_o   (strobe_rise)
    );

    assign eff_word = effective_word(active_word, bypass_i);

    adb_tap_delay #(.W(PIX_W), .TAP_W(TAP_W)) u_dly_a (
        .clk_i(clk_i), .rst_i(rst_i), .din_i(pix_a_i), .sel_i(eff_word.pix_a), .dout_o(pix_a_o));
    adb_tap_delay #(.W(PIX_W), .TAP_W(TAP_W)) u_dly_b (
        .clk_i(clk_i), .rst_i(rst_i), .din_i(pix_b_i), .sel_i(eff_word.pix_b), .dout_o(pix_b_o));
    adb_tap_delay #(.W(MIX_W), .TAP_W(TAP_W)) u_dly_m (
        .clk_i(clk_i), .rst_i(rst_i), .din_i(mix_i), .sel_i(eff_word.mix), .dout_o(mix_o));
    adb_tap_delay #(.W(RND_W), .TAP_W(TAP_W)) u_dly_r (
        .clk_i(clk_i), .rst_i(rst_i), .din_i(rnd_i), .sel_i(eff_word.rnd), .dout_o(rnd_o));
    adb_tap_delay #(.W(FMT_W), .TAP_W(TAP_W)) u_dly_f (
        .clk_i(clk_i), .rst_i(rst_i), .din_i(fmt_i), .sel_i(eff_word.fmt), .dout_o(fmt_o));
endmodule

// File: rtl/adb_checker.sv
`timescale 1ns/1ps
module adb_checker
    import adb_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             bypass_i,
    input logic [PIX_W-1:0] pix_a_i,
    input logic [PIX_W-1:0] pix_b_i,
    input logic [MIX_W-1:0] mix_i,
    input logic [RND_W-1:0] rnd_i,
    input logic [FMT_W-1:0] fmt_i,
    input logic [PIX_W-1:0] pix_a_o,
    input logic [PIX_W-1:0] pix_b_o,
    input logic [MIX_W-1:0] mix_o,
    input logic [RND_W-1:0] rnd_o,
    input logic [FMT_W-1:0] fmt_o,
    input dly_word_t        word_i,
    input dly_word_t        eff_i,
    input cnt_t             cnt_i,
    input logic             rise_i
);
    // R7
    reset_clear_chk: assert property (@(posedge clk_i)
        rst_i |=> (word_i == '0 && cnt_i == '0));

    // R6
    bypass_pass_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bypass_i |-> (pix_a_o == pix_a_i && pix_b_o == pix_b_i && mix_o == mix_i
                      && rnd_o == rnd_i && fmt_o == fmt_i));

    // R4
    word_commit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$stable(word_i) |-> $past(rise_i && cnt_i == LAST_BIT));

    // R5
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_i <= LAST_BIT);

    // R5
    cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (rise_i && cnt_i == LAST_BIT) |=> (cnt_i == '0));

    // R8
    single_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rise_i |=> !rise_i);

    // R1
    one_cycle_tap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $stable(eff_i) && eff_i.pix_a == 3'd1) |-> (pix_a_o == $past(pix_a_i)));
endmodule

bind alignment_delay_bank adb_checker u_chk (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .bypass_i (bypass_i),
    .pix_a_i  (pix_a_i),
    .pix_b_i  (pix_b_i),
    .mix_i    (mix_i),
    .rnd_i    (rnd_i),
    .fmt_i    (fmt_i),
    .pix_a_o  (pix_a_o),
    .pix_b_o  (pix_b_o),
    .mix_o    (mix_o),
    .rnd_o    (rnd_o),
    .fmt_o    (fmt_o),
    .word_i   (active_word),
    .eff_i    (eff_word),
    .cnt_i    (load_cnt),
    .rise_i   (strobe_rise)
);

// File: tb/alignment_delay_bank_tb_top.sv
`timescale 1ns/1ps
module alignment_delay_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] pix_a = '0, pix_b = '0, mix = '0;
    logic [1:0]  rnd = '0;
    logic [0:0]  fmt = '0;
    logic        ld_strobe = 1'b0, ld_data = 1'b0, bypass = 1'b0;
    logic [11:0] pix_a_o, pix_b_o, mix_o;
    logic [1:0]  rnd_o;
    logic [0:0]  fmt_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    cmp_en   = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R7";
    logic [14:0] m_word = '0;

    logic [11:0] ha [7];
    logic [11:0] hb [7];
    logic [11:0] hm [7];
    logic [1:0]  hr [7];
    logic [0:0]  hf [7];

    always #2 clk = ~clk;

    alignment_delay_bank dut_i (
        .clk_i(clk), .rst_i(rst),
        .pix_a_i(pix_a), .pix_b_i(pix_b), .mix_i(mix), .rnd_i(rnd), .fmt_i(fmt),
        .ld_strobe_i(ld_strobe), .ld_data_i(ld_data), .bypass_i(bypass),
        .pix_a_o(pix_a_o), .pix_b_o(pix_b_o), .mix_o(mix_o), .rnd_o(rnd_o), .fmt_o(fmt_o)
    );

    task automatic chk(input string req, input string nm, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    endtask

    // Free-running random input patterns, changed on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            pix_a = 12'($urandom);
            pix_b = 12'($urandom);
            mix   = 12'($urandom);
            rnd   = 2'($urandom);
            fmt   = 1'($urandom);
        end
    end

    // Behavioural reference: history of past inputs, compared every cycle.
    always begin
        @(posedge clk);
        if (rst) begin
            for (int k = 0; k < 7; k++) begin
                ha[k] = '0; hb[k] = '0; hm[k] = '0; hr[k] = '0; hf[k] = '0;
            end
            m_word = '0;
        end else begin
            for (int k = 6; k > 0; k--) begin
                ha[k] = ha[k-1]; hb[k] = hb[k-1]; hm[k] = hm[k-1];
                hr[k] = hr[k-1]; hf[k] = hf[k-1];
            end
            ha[0] = pix_a; hb[0] = pix_b; hm[0] = mix; hr[0] = rnd; hf[0] = fmt;
        end
        #1;
        if (cmp_en) begin
            int da, db, dm, dr, df;
            logic [14:0] eff;
            eff = bypass ? 15'd0 : m_word;
            da = int'(eff[2:0]);  db = int'(eff[5:3]);  dm = int'(eff[8:6]);
            dr = int'(eff[11:9]); df = int'(eff[14:12]);
            chk(cur_req, "pix_a", int'(pix_a_o), (da == 0) ? int'(pix_a) : int'(ha[da-1]));
            chk(cur_req, "pix_b", int'(pix_b_o), (db == 0) ? int'(pix_b) : int'(hb[db-1]));
            chk(cur_req, "mix",   int'(mix_o),   (dm == 0) ? int'(mix)   : int'(hm[dm-1]));
            chk(cur_req, "rnd",   int'(rnd_o),   (dr == 0) ? int'(rnd)   : int'(hr[dr-1]));
            chk(cur_req, "fmt",   int'(fmt_o),   (df == 0) ? int'(fmt)   : int'(hf[df-1]));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bit(input logic b, input int hold);
        @(negedge clk);
        ld_data = b;
        wait_cyc(2);
        ld_strobe = 1'b1;
        wait_cyc(hold);
        ld_strobe = 1'b0;
        wait_cyc(3);
    endtask

    // Sends bits lo..hi of w. Comparison pauses across the committing pulse.
    task automatic send_bits(input logic [14:0] w, input int lo, input int hi, input int hold);
        for (int i = lo; i <= hi; i++) begin
            if (i == 14) cmp_en = 1'b0;
            pulse_bit(w[i], hold);
        end
        if (hi == 14) begin
            wait_cyc(2);
            m_word = w;
            cmp_en = 1'b1;
        end
    endtask

    initial begin
        // R7: reset state, all paths pass through
        cur_req = "R7";
        cmp_en  = 1'b1;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(20);

        // R3: serial order, then R2 field mapping
        cur_req = "R3";
        send_bits({3'd7, 3'd0, 3'd5, 3'd3, 3'd1}, 0, 14, 4);
        cur_req = "R2";
        wait_cyc(40);

        // R1: extreme taps 0 and 7 and intermediate values
        cur_req = "R1";
        send_bits({3'd6, 3'd2, 3'd4, 3'd7, 3'd0}, 0, 14, 4);
        wait_cyc(40);

        // R4: partial load leaves delays unchanged
        cur_req = "R4";
        send_bits({3'd1, 3'd7, 3'd3, 3'd2, 3'd5}, 0, 6, 4);
        wait_cyc(20);
        // R5: completing the word, then a second full load after the wrap
        cur_req = "R5";
        send_bits({3'd1, 3'd7, 3'd3, 3'd2, 3'd5}, 7, 14, 4);
        wait_cyc(30);
        send_bits({3'd3, 3'd5, 3'd1, 3'd6, 3'd7}, 0, 14, 4);
        wait_cyc(30);

        // R8: long strobe holds count once each
        cur_req = "R8";
        send_bits({3'd2, 3'd4, 3'd6, 3'd0, 3'd3}, 0, 14, 20);
        wait_cyc(30);

        // R6: bypass over a nonzero word, then release
        cur_req = "R6";
        @(negedge clk);
        bypass = 1'b1;
        wait_cyc(30);
        bypass = 1'b0;
        wait_cyc(30);

        // R7: reset mid-load clears word and pulse count
        cur_req = "R7";
        send_bits(15'h7fff, 0, 4, 4);
        @(negedge clk);
        rst = 1'b1;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(10);
        send_bits({3'd5, 3'd1, 3'd7, 3'd4, 3'd2}, 0, 14, 4);
        wait_cyc(40);

        cmp_en = 1'b0;
        wait_cyc(2);
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
            $finish;
        end
    end
endmodule